// File: doc/BRIEF.md
# Separate-Space Stack Pointer Unit

This block looks after a hardware stack held in a RAM with its own address space, apart from code memory and data memory. A 16-bit pointer register drives the stack RAM address lines directly. The stack starts at the highest address and grows toward lower addresses. The main sequencer issues one command at a time. There are five commands: push, pop, call, return and pointer reset. The unit then runs the RAM access by itself and signals completion with a one-cycle done pulse. Because the stack has its own RAM, instruction fetch can go on in parallel with these accesses.

Push and pop move words between the stack RAM and the register bus. Call and return use the main data bus instead. Call stores the return address that is present on that bus. Return reads a stored address back and presents it on the same bus. Every command follows the same pattern: it is accepted, then spends one cycle in an address phase and one in a data phase that carries the RAM strobe. One more cycle captures any read word, and done follows. If a pop or return is issued while the stack is empty, a sticky underflow flag is set and the pointer is not changed.

Top module: `stack_unit`

## Requirements
- R1: After a synchronous reset, `ram_addr` is 0xFFFF, and `busy`, `done`, `underflow`, both strobes and both output-valid flags are low.
- R2: `ram_addr` is the stack pointer itself. It changes only at the points named below.
- R3: Push (`cmd_op`=1) captures `rbus_in` at acceptance. `ram_we` is high for one cycle, two cycles after acceptance, at the unchanged pointer. The pointer then drops by one at the end of that strobe cycle.
- R4: Pop (`cmd_op`=2) adds one to the pointer at acceptance. `ram_re` is high two cycles after acceptance, at the new pointer. The word read is placed on `rbus_out` with `rbus_out_valid` high in the done cycle.
- R5: Call (`cmd_op`=3) behaves like push, except that the stored word comes from `dbus_in`.
- R6: Return (`cmd_op`=4) behaves like pop, except that the word goes to `dbus_out` with `dbus_out_valid`, and `rbus_out_valid` stays low.
- R7: Pointer reset (`cmd_op`=5) loads 0xFFFF at acceptance and clears `underflow`. It raises no RAM strobe.
- R8: A command is accepted only while `busy` is low. `busy` rises on the cycle after acceptance, and `done` is a single-cycle pulse four cycles after acceptance. `cmd_valid` is ignored while `busy` is high, and the two strobes are never high together.
- R9: A pop or return accepted while the pointer is 0xFFFF sets the sticky `underflow` flag. The pointer stays the same, no read strobe is raised and no output-valid is raised, but `done` still follows.
- R10: The op codes 0, 6 and 7 are ignored. They leave the unit idle and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe from the sequencer |
| cmd_op | input | 3 | Command code (1 push, 2 pop, 3 call, 4 return, 5 pointer reset) |
| rbus_in | input | DW | Register bus word to push |
| dbus_in | input | DW | Return address to store on call |
| rbus_out | output | DW | Word popped to the register bus |
| rbus_out_valid | output | 1 | High in the done cycle of a successful pop |
| dbus_out | output | DW | Address returned to the data bus |
| dbus_out_valid | output | 1 | High in the done cycle of a successful return |
| ram_addr | output | AW | Stack RAM address, which is the pointer |
| ram_we | output | 1 | Stack RAM write strobe |
| ram_re | output | 1 | Stack RAM read strobe (data arrives one cycle later) |
| ram_wdata | output | DW | Stack RAM write data |
| ram_rdata | input | DW | Stack RAM read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| underflow | output | 1 | Sticky empty-stack pop flag |

## Verification
The pointer drives `ram_addr`, so a wrong pointer value shows up at the ports in the very cycle the register changes, with no need to wait for a later access. A sequencer phase that is off by one shows up one cycle early or late in the strobes, `busy` or `done`. An error in the write-data capture or the read capture stays hidden until the matching pop or return presents the word. The bench therefore pairs every push with a later pop. It also compares all outputs against a model on every clock, so that the first wrong cycle is the one reported.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RSP  = 3'd5
  } stk_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_WAIT,
    PH_DONE
  } stk_phase_e;

  function automatic logic op_known(input logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd5);
  endfunction

  function automatic logic op_writes(input logic [2:0] op);
    return (op == OP_PUSH) || (op == OP_CALL);
  endfunction

  function automatic logic op_reads(input logic [2:0] op);
    return (op == OP_POP) || (op == OP_RET);
  endfunction

endpackage

// File: rtl/stk_pointer.sv
module stk_pointer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_top,
  input  logic          step_up,
  input  logic          step_down,
  output logic [AW-1:0] ptr,
  output logic          at_top
);
  localparam logic [AW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || load_top)  ptr <= TOP;
    else if (step_up)     ptr <= ptr + 1'b1;
    else if (step_down)   ptr <= ptr - 1'b1;
  end

  assign at_top = (ptr == TOP);
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       at_top,
  output logic       accept,
  output logic       src_dbus,
  output logic       load_top,
  output logic       step_up,
  output logic       step_down,
  output logic       cap_r,
  output logic       cap_d,
  output logic       ram_we,
  output logic       ram_re,
  output logic       done,
  output logic       busy,
  output logic       underflow
);
  stk_phase_e phase;
  stk_op_e    op_q;
  logic       miss_q;

  assign accept    = (phase == PH_IDLE) && cmd_valid && op_known(cmd_op);
  assign src_dbus  = (cmd_op == OP_CALL);
  assign load_top  = accept && (cmd_op == OP_RSP);
  assign step_up   = accept && op_reads(cmd_op) && !at_top;
  assign step_down = (phase == PH_DATA) && op_writes(op_q);
  assign cap_r     = (phase == PH_WAIT) && (op_q == OP_POP) && !miss_q;
  assign cap_d     = (phase == PH_WAIT) && (op_q == OP_RET) && !miss_q;
  assign busy      = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      op_q      <= OP_NONE;
      miss_q    <= 1'b0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      done      <= 1'b0;
      underflow <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      ram_re <= 1'b0;
      done   <= 1'b0;
      case (phase)
        PH_IDLE: if (accept) begin
          phase  <= PH_ADDR;
          op_q   <= stk_op_e'(cmd_op);
          miss_q <= op_reads(cmd_op) && at_top;
          if (op_reads(cmd_op) && at_top) underflow <= 1'b1;
          if (cmd_op == OP_RSP)           underflow <= 1'b0;
        end
        PH_ADDR: begin
          phase  <= PH_DATA;
          ram_we <= op_writes(op_q);
          ram_re <= op_reads(op_q) && !miss_q;
        end
        PH_DATA: phase <= PH_WAIT;
        PH_WAIT: begin
          phase <= PH_DONE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_data.sv
module stk_data #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          src_dbus,
  input  logic [DW-1:0] rbus_in,
  input  logic [DW-1:0] dbus_in,
  input  logic [DW-1:0] ram_rdata,
  input  logic          cap_r,
  input  logic          cap_d,
  output logic [DW-1:0] ram_wdata,
  output logic [DW-1:0] rbus_out,
  output logic          rbus_out_valid,
  output logic [DW-1:0] dbus_out,
  output logic          dbus_out_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_wdata      <= '0;
      rbus_out       <= '0;
      dbus_out       <= '0;
      rbus_out_valid <= 1'b0;
      dbus_out_valid <= 1'b0;
    end else begin
      if (accept) ram_wdata <= src_dbus ? dbus_in : rbus_in;
      if (cap_r)  rbus_out  <= ram_rdata;
      if (cap_d)  dbus_out  <= ram_rdata;
      rbus_out_valid <= cap_r;
      dbus_out_valid <= cap_d;
    end
  end
endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] rbus_in,
  input  logic [DW-1:0] dbus_in,
  output logic [DW-1:0] rbus_out,
  output logic          rbus_out_valid,
  output logic [DW-1:0] dbus_out,
  output logic          dbus_out_valid,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          busy,
  output logic          done,
  output logic          underflow
);
  logic accept, src_dbus, load_top, step_up, step_down, cap_r, cap_d, at_top;

  stk_seq u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .at_top(at_top), .accept(accept), .src_dbus(src_dbus),
    .load_top(load_top), .step_up(step_up), .step_down(step_down),
    .cap_r(cap_r), .cap_d(cap_d), .ram_we(ram_we), .ram_re(ram_re),
    .done(done), .busy(busy), .underflow(underflow)
  );

  stk_pointer #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load_top(load_top), .step_up(step_up),
    .step_down(step_down), .ptr(ram_addr), .at_top(at_top)
  );

  stk_data #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .accept(accept), .src_dbus(src_dbus),
    .rbus_in(rbus_in), .dbus_in(dbus_in), .ram_rdata(ram_rdata),
    .cap_r(cap_r), .cap_d(cap_d), .ram_wdata(ram_wdata),
    .rbus_out(rbus_out), .rbus_out_valid(rbus_out_valid),
    .dbus_out(dbus_out), .dbus_out_valid(dbus_out_valid)
  );
endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] ram_addr,
  input logic          ram_we,
  input logic          ram_re,
  input logic          busy,
  input logic          done,
  input logic          underflow,
  input logic          rbus_out_valid,
  input logic          dbus_out_valid
);
  assert_reset_top_R1: assert property (@(posedge clk)
    rst |=> (ram_addr == {AW{1'b1}}) && !busy && !underflow && !done);

  assert_push_step_R3: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> ram_addr == $past(ram_addr) - 1'b1);

  assert_pop_valid_R4: assert property (@(posedge clk) disable iff (rst)
    rbus_out_valid |-> done && !dbus_out_valid);

  assert_ret_valid_R6: assert property (@(posedge clk) disable iff (rst)
    dbus_out_valid |-> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));

  assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |-> busy);

  assert_underflow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> $stable(ram_addr));
endmodule

bind stack_unit stack_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ram_addr(ram_addr), .ram_we(ram_we),
  .ram_re(ram_re), .busy(busy), .done(done), .underflow(underflow),
  .rbus_out_valid(rbus_out_valid), .dbus_out_valid(dbus_out_valid)
);

// File: tb/tb_stack_unit.sv
module tb_stack_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] rbus_in = '0, dbus_in = '0;
  logic [15:0] rbus_out, dbus_out, ram_wdata;
  logic [15:0] ram_rdata = '0;
  logic [15:0] ram_addr;
  logic        rbus_out_valid, dbus_out_valid, ram_we, ram_re, busy, done, underflow;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  stack_unit dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rbus_in(rbus_in), .dbus_in(dbus_in), .rbus_out(rbus_out),
    .rbus_out_valid(rbus_out_valid), .dbus_out(dbus_out),
    .dbus_out_valid(dbus_out_valid), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_re(ram_re), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .busy(busy), .done(done), .underflow(underflow)
  );

  // stack RAM model, one-cycle read
  logic [15:0] sram [int];
  always @(posedge clk) begin
    if (ram_we) sram[int'(ram_addr)] = ram_wdata;
    if (ram_re) ram_rdata <= sram.exists(int'(ram_addr)) ? sram[int'(ram_addr)] : 16'h0;
  end

  // behavioural reference model
  logic [15:0] mmem [int];
  int          m_phase = 0;
  int          m_op = 0;
  int          m_sp = 16'hFFFF;
  bit          m_miss = 0, m_uf = 0, m_done = 0, m_we = 0, m_re = 0, m_rv = 0, m_dv = 0;
  logic [15:0] m_data = '0, m_rout = '0, m_dout = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_sp = 16'hFFFF; m_uf = 0; m_done = 0;
      m_we = 0; m_re = 0; m_rv = 0; m_dv = 0; m_rout = '0; m_dout = '0;
    end else begin
      case (m_phase)
        0: if (cmd_valid && cmd_op >= 3'd1 && cmd_op <= 3'd5) begin
          m_op = int'(cmd_op);
          m_data = (cmd_op == 3'd3) ? dbus_in : rbus_in;
          m_miss = 0;
          m_phase = 1;
          if (m_op == 2 || m_op == 4) begin
            if (m_sp == 16'hFFFF) begin m_miss = 1; m_uf = 1; end
            else m_sp = m_sp + 1;
          end
          if (m_op == 5) begin m_sp = 16'hFFFF; m_uf = 0; end
        end
        1: begin
          m_phase = 2;
          m_we = (m_op == 1 || m_op == 3);
          m_re = (m_op == 2 || m_op == 4) && !m_miss;
        end
        2: begin
          m_phase = 3; m_we = 0; m_re = 0;
          if (m_op == 1 || m_op == 3) begin
            mmem[m_sp] = m_data;
            m_sp = (m_sp - 1) & 16'hFFFF;
          end
        end
        3: begin
          m_phase = 4; m_done = 1;
          if (!m_miss && m_op == 2) begin
            m_rv = 1; m_rout = mmem.exists(m_sp) ? mmem[m_sp] : 16'h0;
          end
          if (!m_miss && m_op == 4) begin
            m_dv = 1; m_dout = mmem.exists(m_sp) ? mmem[m_sp] : 16'h0;
          end
        end
        default: begin m_phase = 0; m_done = 0; m_rv = 0; m_dv = 0; end
      endcase
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  bit compare_on = 0;
  always @(negedge clk) if (compare_on) begin
    chk("R2 ram_addr",        ram_addr, m_sp[15:0]);
    chk("R8 busy",            16'(busy), 16'(m_phase != 0));
    chk("R8 done",            16'(done), 16'(m_done));
    chk("R3 R5 ram_we",       16'(ram_we), 16'(m_we));
    chk("R4 R6 ram_re",       16'(ram_re), 16'(m_re));
    chk("R9 underflow",       16'(underflow), 16'(m_uf));
    chk("R4 rbus_out_valid",  16'(rbus_out_valid), 16'(m_rv));
    chk("R6 dbus_out_valid",  16'(dbus_out_valid), 16'(m_dv));
    if (m_rv) chk("R4 rbus_out", rbus_out, m_rout);
    if (m_dv) chk("R6 dbus_out", dbus_out, m_dout);
    if (m_we) chk("R3 R5 ram_wdata", ram_wdata, m_data);
  end

  task automatic issue(input logic [2:0] op, input logic [15:0] rv, input logic [15:0] dv);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; rbus_in = rv; dbus_in = dv;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 addr", ram_addr, 16'hFFFF);
    chk("R1 busy", 16'(busy), 16'h0);
    chk("R1 underflow", 16'(underflow), 16'h0);
    chk("R1 valids", 16'({rbus_out_valid, dbus_out_valid, ram_we, ram_re, done}), 16'h0);
    compare_on = 1;

    // R3 / R4 push three, pop three (LIFO order)
    issue(3'd1, 16'hA001, 16'h0);
    issue(3'd1, 16'hB002, 16'h0);
    issue(3'd1, 16'hC003, 16'h0);
    chk("R3 depth", ram_addr, 16'hFFFC);
    issue(3'd2, 16'h0, 16'h0);
    issue(3'd2, 16'h0, 16'h0);
    issue(3'd2, 16'h0, 16'h0);
    chk("R4 back to top", ram_addr, 16'hFFFF);

    // R9 underflow on pop and return at top
    issue(3'd2, 16'h0, 16'h0);
    chk("R9 flag", 16'(underflow), 16'h1);
    issue(3'd4, 16'h0, 16'h0);
    chk("R9 addr held", ram_addr, 16'hFFFF);

    // R7 pointer reset clears flag
    issue(3'd1, 16'h1111, 16'h0);
    issue(3'd5, 16'h0, 16'h0);
    chk("R7 addr", ram_addr, 16'hFFFF);
    chk("R7 flag cleared", 16'(underflow), 16'h0);

    // R5 / R6 call and return on the data bus, mixed with push/pop
    issue(3'd3, 16'hDEAD, 16'h1234);
    issue(3'd1, 16'h5A5A, 16'hFFFF);
    issue(3'd2, 16'h0, 16'h0);
    issue(3'd4, 16'h0, 16'h0);
    chk("R6 ret word", dbus_out, 16'h1234);

    // R10 unknown op codes
    issue(3'd1, 16'h7777, 16'h0);
    issue(3'd6, 16'h0, 16'h0);
    issue(3'd7, 16'h0, 16'h0);
    issue(3'd0, 16'h0, 16'h0);
    chk("R10 idle", 16'(busy), 16'h0);
    chk("R10 addr", ram_addr, 16'hFFFE);

    // R8 command while busy is ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; rbus_in = 16'h4242;
    @(negedge clk);
    cmd_op = 3'd2;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    repeat (5) @(negedge clk);
    chk("R8 busy cmd ignored", ram_addr, 16'hFFFD);

    // deeper run
    for (int i = 0; i < 20; i++) issue(3'd1, 16'(i * 16'h0101 + 3), 16'h0);
    for (int i = 0; i < 22; i++) issue((i % 2 == 0) ? 3'd2 : 3'd4, 16'h0, 16'h0);
    chk("R4 drained", ram_addr, 16'hFFFF);
    issue(3'd4, 16'h0, 16'h0);
    chk("R9 final flag", 16'(underflow), 16'h1);

    repeat (3) @(negedge clk);
    compare_on = 0;
    finish_run();
  end
endmodule